// File: doc/BRIEF.md
# Search-Coprocessor Read Transaction Responder

This block is the device side of a single-location read on a shared, bidirectional 68-bit host bus. In one cycle the host presents a read command together with an address word. The responder decides from that word whether it is the addressed device. It accepts when the 5-bit device field matches its own ID. It also accepts a broadcast code, but only when it is the last device in the chain. It then forms an array address, either taken straight from the word or built from one of eight segment-select registers. It reads the data array or the mask array through a synchronous memory port with one cycle of latency.

The responder then plays a fixed turnaround on the bus. For two cycles it drives nothing while the host releases the bus. It turns its drivers on with acknowledge low, puts the read word out with acknowledge high, and releases the data bus with acknowledge low. After that it releases acknowledge as well. The tri-state pins are modelled as separate value and output-enable signals, so the pad ring owns the actual buffers.

The host bus has fixed timing and no back-pressure. A command is taken or ignored in the cycle it appears. The memory port has no ready signal and must return data exactly one cycle after the request. Segment registers load through a plain write strobe.

Top module: `srch_rd_resp`

## Requirements
- R1: A read is recognised in a cycle where `cmd_valid` is 1, `cmd[2]` is 0 and `cmd[1:0]` equals the READ_OP parameter (default 2'b00). Any other opcode, or `cmd[2]` = 1, starts nothing.
- R2: With a device field `bus_in[25:21]` other than 5'b11111, the block responds only when that field equals `dev_id`.
- R3: With a device field of 5'b11111, the block responds exactly when `last_dev` is 1, whatever `dev_id` holds.
- R4: The target field `bus_in[20:19]` selects the data array with 2'b00 (`arr_rd_sel` = 0) and the mask array with 2'b01 (`arr_rd_sel` = 1). The codes 2'b10 and 2'b11 are ignored: there is no memory request and no enable rises.
- R5: With `bus_in[29]` = 0, the array address is `bus_in[13:0]`. Bits 67:30 and 18:14 have no effect.
- R6: With `bus_in[29]` = 1, the segment register indexed by `bus_in[28:26]` supplies the address. Its bits 13:2 are used unchanged and its bits 1:0 are ORed with `bus_in[1:0]`.
- R7: The memory request `arr_rd_en` is high for exactly one cycle, the second cycle of the transaction, with `arr_rd_addr` and `arr_rd_sel` valid. `arr_rd_data` is taken one cycle later.
- R8: In the second and third cycles, `dq_oe` and `ack_oe` are both 0.
- R9: In the fourth cycle, `dq_oe` = 1 with `dq_out` = 0, and `ack_oe` = 1 with `ack_out` = 0. `dq_out` is 0 in every cycle where the read word is not being presented.
- R10: In the fifth cycle, `dq_oe` = 1 with `dq_out` equal to the word read, and `ack_oe` = 1 with `ack_out` = 1.
- R11: In the sixth cycle, `dq_oe` = 0 and `ack_oe` = 1 with `ack_out` = 0. From the next cycle `ack_oe` is 0, and a command in that cycle is accepted.
- R12: Commands that arrive during cycles two to six are ignored.
- R13: A segment register loads `cfg_wr_data` at the clock edge where `cfg_wr_en` is 1, indexed by `cfg_wr_idx`. An indirect read in that same cycle uses the old value.
- R14: An active-low `rst_n` clears all segment registers to 0 and abandons any transaction. All enables go to 0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe from host |
| cmd | input | 3 | Command code, bit 2 must be 0 for a read |
| bus_in | input | 68 | Value seen on the shared data bus |
| dev_id | input | 5 | This device's ID |
| last_dev | input | 1 | This device answers the broadcast code |
| cfg_wr_en | input | 1 | Segment register write strobe |
| cfg_wr_idx | input | 3 | Segment register index |
| cfg_wr_data | input | 14 | Segment register value |
| arr_rd_en | output | 1 | Array read request |
| arr_rd_sel | output | 1 | 0 data array, 1 mask array |
| arr_rd_addr | output | 14 | Array word address |
| arr_rd_data | input | 68 | Array word, one cycle after request |
| dq_out | output | 68 | Value for the data bus drivers |
| dq_oe | output | 1 | Data bus driver enable |
| ack_out | output | 1 | Value for the acknowledge driver |
| ack_oe | output | 1 | Acknowledge driver enable |

## Verification
The checker follows the handshake shape on every cycle. Each memory request traces back to a read command and is followed by a quiet gap and then the lead cycle. Acknowledge high must come straight after a driven low and be followed by the tail. Acknowledge must be released after the tail. The data bus never drives without acknowledge and never shows a non-zero value while disabled. The address arithmetic, the ID and broadcast decisions, the ignored target codes and the commands dropped while busy cannot be seen by those properties. Only the bench's scenarios against its reference model show them, together with the write-then-read ordering of the segment registers and the re-acceptance in the cycle after release.

// File: rtl/srch_rd_pkg.sv
package srch_rd_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_GAP_A,
    PH_GAP_B,
    PH_LEAD,
    PH_DATA,
    PH_TAIL
  } rd_phase_t;

  localparam int POS_IND    = 29;
  localparam int POS_IDX_LO = 26;
  localparam int POS_ID_LO  = 21;
  localparam int POS_TGT_LO = 19;
  localparam int POS_RSV_LO = 14;

  localparam logic [1:0] TGT_DATA = 2'b00;
  localparam logic [1:0] TGT_MASK = 2'b01;
endpackage

// File: rtl/srch_seg_regs.sv
module srch_seg_regs #(
  parameter int SEG_N  = 8,
  parameter int ADDR_W = 14,
  localparam int IDX_W = $clog2(SEG_N)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [ADDR_W-1:0]              wr_data,
  output logic [SEG_N-1:0][ADDR_W-1:0]   seg_q
);
  for (genvar g = 0; g < SEG_N; g++) begin : g_seg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        seg_q[g] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        seg_q[g] <= wr_data;
    end
  end
endmodule

// File: rtl/srch_rd_decode.sv
module srch_rd_decode
  import srch_rd_pkg::*;
#(
  parameter int         DATA_W  = 68,
  parameter int         ADDR_W  = 14,
  parameter int         ID_W    = 5,
  parameter int         SEG_N   = 8,
  parameter logic [1:0] READ_OP = 2'b00,
  localparam int        IDX_W   = $clog2(SEG_N)
) (
  input  logic                         cmd_valid,
  input  logic [2:0]                   cmd,
  input  logic [DATA_W-1:0]            bus_in,
  input  logic [ID_W-1:0]              dev_id,
  input  logic                         last_dev,
  input  logic [SEG_N-1:0][ADDR_W-1:0] seg_q,
  output logic                         hit,
  output logic                         mask_sel,
  output logic [ADDR_W-1:0]            addr
);
  logic [ID_W-1:0]   id_f;
  logic [1:0]        tgt_f;
  logic [IDX_W-1:0]  idx_f;
  logic              ind_f;
  logic [ADDR_W-1:0] seg_v;
  logic              is_read, chosen, tgt_ok;
  logic              unused_rsvd;

  assign id_f  = bus_in[POS_ID_LO +: ID_W];
  assign tgt_f = bus_in[POS_TGT_LO +: 2];
  assign idx_f = bus_in[POS_IDX_LO +: IDX_W];
  assign ind_f = bus_in[POS_IND];
  assign unused_rsvd = ^{bus_in[DATA_W-1:POS_IND+1], bus_in[POS_TGT_LO-1:POS_RSV_LO]};

  assign is_read = cmd_valid && !cmd[2] && (cmd[1:0] == READ_OP);
  assign chosen  = (&id_f) ? last_dev : (id_f == dev_id);
  assign tgt_ok  = (tgt_f == TGT_DATA) || (tgt_f == TGT_MASK);
  assign hit     = is_read && chosen && tgt_ok;
  assign mask_sel = (tgt_f == TGT_MASK);

  always_comb begin
    seg_v = seg_q[idx_f];
    if (ind_f)
      addr = {seg_v[ADDR_W-1:2], seg_v[1:0] | bus_in[1:0]};
    else
      addr = bus_in[ADDR_W-1:0];
  end
endmodule

// File: rtl/srch_rd_seq.sv
module srch_rd_seq
  import srch_rd_pkg::*;
#(
  parameter int DATA_W = 68,
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              hit_mask,
  input  logic [ADDR_W-1:0] hit_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              idle,
  output logic              mem_rd_en,
  output logic              mem_sel,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              ack_out,
  output logic              ack_oe
);
  rd_phase_t         phase, phase_nx;
  logic [DATA_W-1:0] word_q;

  assign idle = (phase == PH_IDLE);

  always_comb begin
    unique case (phase)
      PH_IDLE:  phase_nx = hit ? PH_GAP_A : PH_IDLE;
      PH_GAP_A: phase_nx = PH_GAP_B;
      PH_GAP_B: phase_nx = PH_LEAD;
      PH_LEAD:  phase_nx = PH_DATA;
      PH_DATA:  phase_nx = PH_TAIL;
      default:  phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      mem_sel  <= 1'b0;
      mem_addr <= '0;
      word_q   <= '0;
    end else begin
      phase <= phase_nx;
      if (idle && hit) begin
        mem_sel  <= hit_mask;
        mem_addr <= hit_addr;
      end
      if (phase == PH_GAP_B)
        word_q <= mem_rdata;
    end
  end

  assign mem_rd_en = (phase == PH_GAP_A);
  assign dq_oe     = (phase == PH_LEAD) || (phase == PH_DATA);
  assign dq_out    = (phase == PH_DATA) ? word_q : '0;
  assign ack_oe    = (phase == PH_LEAD) || (phase == PH_DATA) || (phase == PH_TAIL);
  assign ack_out   = (phase == PH_DATA);
endmodule

// File: rtl/srch_rd_resp.sv
module srch_rd_resp #(
  parameter int         DATA_W  = 68,
  parameter int         ADDR_W  = 14,
  parameter int         ID_W    = 5,
  parameter int         SEG_N   = 8,
  parameter logic [1:0] READ_OP = 2'b00,
  localparam int        IDX_W   = $clog2(SEG_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd,
  input  logic [DATA_W-1:0] bus_in,
  input  logic [ID_W-1:0]   dev_id,
  input  logic              last_dev,
  input  logic              cfg_wr_en,
  input  logic [IDX_W-1:0]  cfg_wr_idx,
  input  logic [ADDR_W-1:0] cfg_wr_data,
  output logic              arr_rd_en,
  output logic              arr_rd_sel,
  output logic [ADDR_W-1:0] arr_rd_addr,
  input  logic [DATA_W-1:0] arr_rd_data,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              ack_out,
  output logic              ack_oe
);
  logic [SEG_N-1:0][ADDR_W-1:0] seg_q;
  logic                         dec_hit, dec_mask, seq_idle;
  logic [ADDR_W-1:0]            dec_addr;

  srch_seg_regs #(.SEG_N(SEG_N), .ADDR_W(ADDR_W)) u_seg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_idx  (cfg_wr_idx),
    .wr_data (cfg_wr_data),
    .seg_q   (seg_q)
  );

  srch_rd_decode #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ID_W(ID_W), .SEG_N(SEG_N), .READ_OP(READ_OP)
  ) u_dec (
    .cmd_valid (cmd_valid),
    .cmd       (cmd),
    .bus_in    (bus_in),
    .dev_id    (dev_id),
    .last_dev  (last_dev),
    .seg_q     (seg_q),
    .hit       (dec_hit),
    .mask_sel  (dec_mask),
    .addr      (dec_addr)
  );

  srch_rd_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (dec_hit),
    .hit_mask  (dec_mask),
    .hit_addr  (dec_addr),
    .mem_rdata (arr_rd_data),
    .idle      (seq_idle),
    .mem_rd_en (arr_rd_en),
    .mem_sel   (arr_rd_sel),
    .mem_addr  (arr_rd_addr),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .ack_out   (ack_out),
    .ack_oe    (ack_oe)
  );

  logic unused_idle;
  assign unused_idle = seq_idle;
endmodule

// File: rtl/srch_rd_chk.sv
module srch_rd_chk #(
  parameter int         DATA_W  = 68,
  parameter logic [1:0] READ_OP = 2'b00
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [2:0]        cmd,
  input logic              arr_rd_en,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_oe,
  input logic              ack_out,
  input logic              ack_oe
);
  AST_REQ_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd_en |-> $past(cmd_valid && !cmd[2] && (cmd[1:0] == READ_OP))); // R1
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd_en |=> !arr_rd_en); // R12
  AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd_en |=> (!dq_oe && !ack_oe)); // R8
  AST_LEAD_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd_en |-> ##2 (dq_oe && ack_oe && !ack_out)); // R9
  AST_DQ_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> ack_oe); // R9
  AST_ACK_HIGH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_oe && ack_out) |-> $past(ack_oe && !ack_out && dq_oe)); // R10
  AST_DQ_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_out == '0)); // R10
  AST_TAIL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_oe && ack_out) |=> (ack_oe && !ack_out && !dq_oe)); // R11
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_oe && !ack_out && !dq_oe) |=> !ack_oe); // R11
endmodule

bind srch_rd_resp srch_rd_chk #(.DATA_W(DATA_W), .READ_OP(READ_OP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd       (cmd),
  .arr_rd_en (arr_rd_en),
  .dq_out    (dq_out),
  .dq_oe     (dq_oe),
  .ack_out   (ack_out),
  .ack_oe    (ack_oe)
);

// File: tb/test_srch_rd_resp.sv
`timescale 1ns/1ps
module test_srch_rd_resp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd = 3'b000;
  logic [67:0] bus_in = '0;
  logic [4:0]  dev_id = 5'd9;
  logic        last_dev = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [2:0]  cfg_wr_idx = '0;
  logic [13:0] cfg_wr_data = '0;
  logic        arr_rd_en, arr_rd_sel, dq_oe, ack_out, ack_oe;
  logic [13:0] arr_rd_addr;
  logic [67:0] arr_rd_data = '0;
  logic [67:0] dq_out;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  string req_tag = "R14";

  always #2.5 clk = ~clk;

  srch_rd_resp i_srch_rd_resp (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .bus_in(bus_in),
    .dev_id(dev_id), .last_dev(last_dev), .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx),
    .cfg_wr_data(cfg_wr_data), .arr_rd_en(arr_rd_en), .arr_rd_sel(arr_rd_sel),
    .arr_rd_addr(arr_rd_addr), .arr_rd_data(arr_rd_data), .dq_out(dq_out),
    .dq_oe(dq_oe), .ack_out(ack_out), .ack_oe(ack_oe)
  );

  function automatic logic [67:0] mem_word(logic sel, logic [13:0] a);
    return {(sel ? 4'hA : 4'h5), {4{a}}, a[7:0] ^ 8'h3c};
  endfunction

  always @(posedge clk) if (arr_rd_en) arr_rd_data <= mem_word(arr_rd_sel, arr_rd_addr);

  // behavioural reference model
  int          ph = 0;
  logic [13:0] seg_m [8];
  logic [13:0] m_addr = '0;
  logic        m_sel = 1'b0;
  logic [67:0] m_word = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0;
      foreach (seg_m[i]) seg_m[i] = '0;
    end else begin
      if (ph == 0) begin
        logic [4:0] idf;
        logic       take;
        idf  = bus_in[25:21];
        take = cmd_valid && !cmd[2] && cmd[1:0] == 2'b00 &&
               ((idf == 5'h1f) ? last_dev : (idf == dev_id)) &&
               (bus_in[20:19] == 2'b00 || bus_in[20:19] == 2'b01);
        if (take) begin
          ph = 2;
          m_sel = bus_in[19];
          if (bus_in[29])
            m_addr = seg_m[bus_in[28:26]] | {12'd0, bus_in[1:0]};
          else
            m_addr = bus_in[13:0];
          m_word = mem_word(m_sel, m_addr);
        end
      end else if (ph == 6) ph = 0;
      else ph = ph + 1;
      if (cfg_wr_en) seg_m[cfg_wr_idx] = cfg_wr_data;
    end
  end

  task automatic chk(string tag, string what, logic [67:0] act, logic [67:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    int p;
    string t;
    p = rst_n ? ph : 0;
    case (p)
      2, 3: t = "R8";
      4: t = "R9";
      5: t = "R10";
      6: t = "R11";
      default: t = req_tag;
    endcase
    chk(t, "arr_rd_en", 68'(arr_rd_en), 68'(p == 2));
    if (p == 2) begin
      chk({req_tag, "/R7"}, "arr_rd_addr", 68'(arr_rd_addr), 68'(m_addr));
      chk("R4", "arr_rd_sel", 68'(arr_rd_sel), 68'(m_sel));
    end
    chk(t, "dq_oe", 68'(dq_oe), 68'(p == 4 || p == 5));
    chk(t, "dq_out", dq_out, (p == 5) ? m_word : 68'd0);
    chk(t, "ack_oe", 68'(ack_oe), 68'(p >= 4 && p <= 6));
    chk(t, "ack_out", 68'(ack_out), 68'(p == 5));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(); @(posedge clk); #1; endtask

  function automatic logic [67:0] word(logic ind, logic [2:0] idx, logic [4:0] id,
                                       logic [1:0] tgt, logic [13:0] a);
    logic [67:0] b;
    b = {38'h2a_5a5a_c3c3, 30'd0};
    b[18:14] = 5'h15;
    b[29] = ind; b[28:26] = idx; b[25:21] = id; b[20:19] = tgt; b[13:0] = a;
    return b;
  endfunction

  task automatic issue(string tag, logic [2:0] c, logic [67:0] b);
    req_tag = tag;
    cmd_valid = 1'b1; cmd = c; bus_in = b;
    step();
    cmd_valid = 1'b0; bus_in = '0;
    repeat (7) step();
  endtask

  task automatic seg_write(logic [2:0] i, logic [13:0] v);
    cfg_wr_en = 1'b1; cfg_wr_idx = i; cfg_wr_data = v;
    step();
    cfg_wr_en = 1'b0;
  endtask

  initial begin
    req_tag = "R14";
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R5 R2 direct data array read with matching ID
    issue("R5", 3'b000, word(1'b0, 3'd0, 5'd9, 2'b00, 14'h1234));
    // R4 mask array
    issue("R4", 3'b000, word(1'b0, 3'd7, 5'd9, 2'b01, 14'h3fff));
    // R13 reset value of segment registers is zero
    issue("R13", 3'b000, word(1'b1, 3'd5, 5'd9, 2'b00, 14'h0002));
    // R6 indirect with OR of low bits
    seg_write(3'd3, 14'h2a55);
    seg_write(3'd6, 14'h1ffc);
    issue("R6", 3'b000, word(1'b1, 3'd3, 5'd9, 2'b00, 14'h000a));
    issue("R6", 3'b000, word(1'b1, 3'd6, 5'd9, 2'b01, 14'h0003));
    // R2 ID mismatch ignored
    issue("R2", 3'b000, word(1'b0, 3'd0, 5'd8, 2'b00, 14'h0011));
    // R3 broadcast code
    issue("R3", 3'b000, word(1'b0, 3'd0, 5'h1f, 2'b00, 14'h0022));
    last_dev = 1'b1;
    issue("R3", 3'b000, word(1'b0, 3'd0, 5'h1f, 2'b01, 14'h0033));
    dev_id = 5'h1f; last_dev = 1'b0;
    issue("R3", 3'b000, word(1'b0, 3'd0, 5'h1f, 2'b00, 14'h0044));
    dev_id = 5'd9;
    // R4 ignored targets
    issue("R4", 3'b000, word(1'b0, 3'd0, 5'd9, 2'b10, 14'h0055));
    issue("R4", 3'b000, word(1'b0, 3'd0, 5'd9, 2'b11, 14'h0066));
    // R1 other opcodes
    issue("R1", 3'b001, word(1'b0, 3'd0, 5'd9, 2'b00, 14'h0077));
    issue("R1", 3'b100, word(1'b0, 3'd0, 5'd9, 2'b00, 14'h0088));
    // R12 R11 held command: busy drops, then re-accepted right after release
    req_tag = "R12";
    cmd_valid = 1'b1; cmd = 3'b000;
    for (int k = 0; k < 14; k++) begin
      bus_in = word(1'b0, 3'd0, 5'd9, k[0] ? 2'b01 : 2'b00, 14'(k * 3 + 100));
      step();
    end
    cmd_valid = 1'b0; bus_in = '0;
    repeat (8) step();
    // R13 write in the same cycle as an indirect read uses the old value
    req_tag = "R13";
    cfg_wr_en = 1'b1; cfg_wr_idx = 3'd3; cfg_wr_data = 14'h0100;
    cmd_valid = 1'b1; bus_in = word(1'b1, 3'd3, 5'd9, 2'b00, 14'h0000);
    step();
    cfg_wr_en = 1'b0; cmd_valid = 1'b0; bus_in = '0;
    repeat (7) step();
    issue("R13", 3'b000, word(1'b1, 3'd3, 5'd9, 2'b00, 14'h0001));
    // R14 reset in the middle of a transaction
    req_tag = "R14";
    cmd_valid = 1'b1; bus_in = word(1'b0, 3'd0, 5'd9, 2'b00, 14'h0abc);
    step();
    cmd_valid = 1'b0; bus_in = '0;
    repeat (3) step();
    rst_n = 1'b0;
    repeat (2) step();
    rst_n = 1'b1;
    issue("R14", 3'b000, word(1'b1, 3'd6, 5'd9, 2'b00, 14'h0001));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule